// File: doc/BRIEF.md
# Sign-Magnitude Iterative Multiply/Divide Engine

This block performs integer multiplication and division on two sign-magnitude registers, one step per clock. The wide register (accumulator) is 38 bits: a sign bit on top, then two overflow guard bits (Q above P), then 35 magnitude bits. The narrow register (multiplier-quotient) is 36 bits: a sign bit on top and 35 magnitude bits. A caller presents both register values, a 36-bit sign-magnitude operand, an operation select and a step count, then pulses `start`. The engine captures everything at that edge and iterates. It then presents the updated register pair together with a one-cycle `done`.

Multiply is add-and-shift. While the low multiplier bit is set, the operand magnitude is added into the 37-bit accumulator magnitude. The joined pair then moves right one place. Divide is shift-and-subtract on the joined pair, with one quotient bit formed per step. The step count is free, from 0 to 255, so a caller can run a partial or an extended sequence. A divide whose high part is already too large is refused at once with a divide-check flag.

The controller has four states. IDLE waits for work. MUL_RUN and DIV_RUN each perform one step per clock. FINISH presents the results for one cycle. Transitions: IDLE→MUL_RUN on an accepted multiply start with a nonzero count and nonzero magnitudes. IDLE→DIV_RUN on an accepted divide start with a nonzero count that is not refused. IDLE→FINISH on any other accepted start (zero count, zero multiply factor, refused divide). MUL_RUN/DIV_RUN→FINISH after the last step. FINISH→IDLE always.

Top module: `sm_muldiv`

## Requirements
- R1: A step count of zero makes either operation a no-op: the cycle after the start edge `done` is high, `div_check` is low, and `ac_out`/`mq_out` equal the values presented at start.
- R2: Multiply: with count N, for each of N steps, if the multiplier's magnitude bit 0 is 1 the operand magnitude (bits 34:0) is added to the accumulator magnitude (bits 36:0, truncated to 37 bits). The 72-bit accumulator:multiplier magnitude then shifts right by one, and accumulator bit 0 enters multiplier bit 34.
- R3: Multiply with a nonzero count and either the operand magnitude or the multiplier magnitude equal to zero clears both magnitudes and finishes the cycle after start, without stepping.
- R4: A multiply with a nonzero count writes the XOR of the multiplier sign (bit 35) and the operand sign (bit 35) into both the accumulator sign (bit 37) and the multiplier sign (bit 35). A positive result clears both sign bits.
- R5: A divide with a nonzero count whose accumulator magnitude (bits 36:0, Q and P included) is not smaller than the operand magnitude is refused. The cycle after start has `done` and `div_check` high, and both registers are unchanged.
- R6: Divide: with count N, for each of N steps, the joined magnitude shifts left by one, and multiplier bit 34 enters accumulator bit 0. If the accumulator magnitude is then at least the divisor, the divisor is subtracted and multiplier bit 0 is set.
- R7: After a divide, the multiplier sign is the XOR of the dividend sign (accumulator bit 37) and the divisor sign (operand bit 35). The accumulator sign is the dividend sign.
- R8: For a stepped operation with count N, `busy` is high for exactly N cycles, starting the cycle after start. `done` follows in the next cycle for one cycle only, and `busy` and `done` are never high together.
- R9: A start is accepted only in IDLE. A start that arrives while busy changes neither the results nor the timing and produces no extra `done`.
- R10: Any count up to 255 is run step by step, including counts beyond the register width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted in IDLE) |
| op_sel | input | 1 | 0 = multiply, 1 = divide |
| step_cnt | input | 8 | Number of steps, 0 to 255 |
| mem_opnd | input | 36 | Operand: sign bit 35, magnitude 34:0 |
| ac_in | input | 38 | Accumulator value at start: sign 37, Q 36, P 35, magnitude 34:0 |
| mq_in | input | 36 | Multiplier-quotient value at start: sign 35, magnitude 34:0 |
| ac_out | output | 38 | Accumulator register |
| mq_out | output | 36 | Multiplier-quotient register |
| busy | output | 1 | Stepping in progress |
| done | output | 1 | One-cycle pulse, results valid |
| div_check | output | 1 | Divide refused; high together with done |

## Verification
Multiply is tried with all four sign combinations at the full 35-step count. This separates a correct product sign from one written into a single register only. A nonzero starting accumulator shows that the adder accumulates rather than loads, and short and 255-step counts show that the step counter, not the data width, ends the run. Divide is tried with quotients that have a nonzero high dividend part, a divisor equal to the high part, and a Q bit set. These separate the strict refusal compare from a wrong one and from a compare that ignores the guard bits. A start injected in mid-run, with different data, shows whether the captured operands are really held.

// File: rtl/sm_muldiv_pkg.sv
package sm_muldiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_MUL_RUN = 2'd1,
        ST_DIV_RUN = 2'd2,
        ST_FINISH  = 2'd3
    } mdu_state_e;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } mdu_op_e;

endpackage

// File: rtl/sm_muldiv_counter.sv
module sm_muldiv_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/sm_muldiv_mul_step.sv
module sm_muldiv_mul_step #(
    parameter int MAG_W = 35
) (
    input  logic [MAG_W+1:0] ac_mag,
    input  logic [MAG_W-1:0] mq_mag,
    input  logic [MAG_W-1:0] mcand,
    output logic [MAG_W+1:0] ac_next,
    output logic [MAG_W-1:0] mq_next
);
    localparam int AM_W = MAG_W + 2;

    logic [AM_W-1:0] partial;

    always_comb begin
        // add when the low multiplier bit is set, truncating to the guard width
        if (mq_mag[0]) begin
            partial = ac_mag + {2'b00, mcand};
        end else begin
            partial = ac_mag;
        end
        mq_next = {partial[0], mq_mag[MAG_W-1:1]};
        ac_next = {1'b0, partial[AM_W-1:1]};
    end
endmodule

// File: rtl/sm_muldiv_div_step.sv
module sm_muldiv_div_step #(
    parameter int MAG_W = 35
) (
    input  logic [MAG_W+1:0] ac_mag,
    input  logic [MAG_W-1:0] mq_mag,
    input  logic [MAG_W-1:0] divisor,
    output logic [MAG_W+1:0] ac_next,
    output logic [MAG_W-1:0] mq_next
);
    localparam int AM_W = MAG_W + 2;

    logic [AM_W-1:0] shifted;
    logic [AM_W-1:0] dvr_ext;
    logic            fits;

    always_comb begin
        shifted = {ac_mag[AM_W-2:0], mq_mag[MAG_W-1]};
        dvr_ext = {2'b00, divisor};
        fits    = (shifted >= dvr_ext);
        ac_next = fits ? (shifted - dvr_ext) : shifted;
        mq_next = {mq_mag[MAG_W-2:0], fits};
    end
endmodule

// File: rtl/sm_muldiv.sv
module sm_muldiv
    import sm_muldiv_pkg::*;
#(
    parameter int MAG_W = 35,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             op_sel,
    input  logic [CNT_W-1:0] step_cnt,
    input  logic [MAG_W:0]   mem_opnd,
    input  logic [MAG_W+2:0] ac_in,
    input  logic [MAG_W:0]   mq_in,
    output logic [MAG_W+2:0] ac_out,
    output logic [MAG_W:0]   mq_out,
    output logic             busy,
    output logic             done,
    output logic             div_check
);
    localparam int AM_W = MAG_W + 2;
    localparam int AC_W = MAG_W + 3;
    localparam int MQ_W = MAG_W + 1;

    mdu_state_e state_q, state_d;

    logic [AM_W-1:0]  ac_mag_q;
    logic [MAG_W-1:0] mq_mag_q;
    logic             ac_sgn_q, mq_sgn_q;
    logic [MAG_W-1:0] dvr_q;
    logic             refused_q;

    logic             accept, running, last_step;
    logic             cnt_zero, div_refuse, mul_zero;
    logic             op_sgn, ac_sgn_in, mq_sgn_in;
    logic [AM_W-1:0]  in_ac_mag;
    logic [MAG_W-1:0] in_mq_mag, op_mag;

    logic [AM_W-1:0]  mul_ac_n, div_ac_n;
    logic [MAG_W-1:0] mul_mq_n, div_mq_n;

    // ---------------- start decode ----------------
    always_comb begin
        accept     = start && (state_q == ST_IDLE);
        running    = (state_q == ST_MUL_RUN) || (state_q == ST_DIV_RUN);
        cnt_zero   = (step_cnt == '0);
        in_ac_mag  = ac_in[AM_W-1:0];
        in_mq_mag  = mq_in[MAG_W-1:0];
        op_mag     = mem_opnd[MAG_W-1:0];
        op_sgn     = mem_opnd[MAG_W];
        ac_sgn_in  = ac_in[AC_W-1];
        mq_sgn_in  = mq_in[MQ_W-1];
        div_refuse = (in_ac_mag >= {2'b00, op_mag});
        mul_zero   = (op_mag == '0) || (in_mq_mag == '0);
    end

    // ---------------- step count ----------------
    sm_muldiv_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (step_cnt),
        .dec      (running),
        .last     (last_step)
    );

    // ---------------- step datapaths ----------------
    sm_muldiv_mul_step #(.MAG_W(MAG_W)) u_mul (
        .ac_mag  (ac_mag_q),
        .mq_mag  (mq_mag_q),
        .mcand   (dvr_q),
        .ac_next (mul_ac_n),
        .mq_next (mul_mq_n)
    );

    sm_muldiv_div_step #(.MAG_W(MAG_W)) u_div (
        .ac_mag  (ac_mag_q),
        .mq_mag  (mq_mag_q),
        .divisor (dvr_q),
        .ac_next (div_ac_n),
        .mq_next (div_mq_n)
    );

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (cnt_zero) begin
                        state_d = ST_FINISH;
                    end else if (op_sel == OP_DIV) begin
                        state_d = div_refuse ? ST_FINISH : ST_DIV_RUN;
                    end else begin
                        state_d = mul_zero ? ST_FINISH : ST_MUL_RUN;
                    end
                end
            end
            ST_MUL_RUN: state_d = last_step ? ST_FINISH : ST_MUL_RUN;
            ST_DIV_RUN: state_d = last_step ? ST_FINISH : ST_DIV_RUN;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- register file ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ac_mag_q  <= '0;
            mq_mag_q  <= '0;
            ac_sgn_q  <= 1'b0;
            mq_sgn_q  <= 1'b0;
            dvr_q     <= '0;
            refused_q <= 1'b0;
        end else if (accept) begin
            dvr_q     <= op_mag;
            refused_q <= 1'b0;
            ac_mag_q  <= in_ac_mag;
            mq_mag_q  <= in_mq_mag;
            ac_sgn_q  <= ac_sgn_in;
            mq_sgn_q  <= mq_sgn_in;
            if (!cnt_zero) begin
                if (op_sel == OP_DIV) begin
                    if (div_refuse) begin
                        refused_q <= 1'b1;
                    end else begin
                        mq_sgn_q <= ac_sgn_in ^ op_sgn;
                    end
                end else begin
                    ac_sgn_q <= mq_sgn_in ^ op_sgn;
                    mq_sgn_q <= mq_sgn_in ^ op_sgn;
                    if (mul_zero) begin
                        ac_mag_q <= '0;
                        mq_mag_q <= '0;
                    end
                end
            end
        end else if (state_q == ST_MUL_RUN) begin
            ac_mag_q <= mul_ac_n;
            mq_mag_q <= mul_mq_n;
        end else if (state_q == ST_DIV_RUN) begin
            ac_mag_q <= div_ac_n;
            mq_mag_q <= div_mq_n;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy      = running;
        done      = (state_q == ST_FINISH);
        div_check = (state_q == ST_FINISH) && refused_q;
        ac_out    = {ac_sgn_q, ac_mag_q};
        mq_out    = {mq_sgn_q, mq_mag_q};
    end
endmodule

// File: rtl/sm_muldiv_checker.sv
module sm_muldiv_checker #(
    parameter int MAG_W = 35,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             op_sel,
    input logic [CNT_W-1:0] step_cnt,
    input logic [MAG_W:0]   mem_opnd,
    input logic [MAG_W+2:0] ac_in,
    input logic [MAG_W:0]   mq_in,
    input logic [MAG_W+2:0] ac_out,
    input logic [MAG_W:0]   mq_out,
    input logic             busy,
    input logic             done,
    input logic             div_check
);
    logic idle_start;
    logic mul_nz_q;

    assign idle_start = start && !busy && !done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mul_nz_q <= 1'b0;
        end else if (idle_start) begin
            mul_nz_q <= (op_sel == 1'b0) && (step_cnt != '0);
        end
    end

    assert_noop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        idle_start && (step_cnt == '0)
        |=> done && !div_check && (ac_out == $past(ac_in)) && (mq_out == $past(mq_in)));

    assert_zero_factor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        idle_start && !op_sel && (step_cnt != '0) &&
        ((mem_opnd[MAG_W-1:0] == '0) || (mq_in[MAG_W-1:0] == '0))
        |=> done && (ac_out[MAG_W+1:0] == '0) && (mq_out[MAG_W-1:0] == '0));

    assert_sign_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done && mul_nz_q |-> (ac_out[MAG_W+2] == mq_out[MAG_W]));

    assert_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        idle_start && op_sel && (step_cnt != '0) &&
        (ac_in[MAG_W+1:0] >= {2'b00, mem_opnd[MAG_W-1:0]})
        |=> done && div_check && (ac_out == $past(ac_in)) && (mq_out == $past(mq_in)));

    assert_check_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        div_check |-> done);

    assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> (busy || done));
endmodule

bind sm_muldiv sm_muldiv_checker #(.MAG_W(MAG_W), .CNT_W(CNT_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_sel    (op_sel),
    .step_cnt  (step_cnt),
    .mem_opnd  (mem_opnd),
    .ac_in     (ac_in),
    .mq_in     (mq_in),
    .ac_out    (ac_out),
    .mq_out    (mq_out),
    .busy      (busy),
    .done      (done),
    .div_check (div_check)
);

// File: tb/sm_muldiv_test.sv
`timescale 1ns/1ps
module sm_muldiv_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_sel = 1'b0;
    logic [7:0]  step_cnt = '0;
    logic [35:0] mem_opnd = '0;
    logic [37:0] ac_in = '0;
    logic [35:0] mq_in = '0;
    logic [37:0] ac_out;
    logic [35:0] mq_out;
    logic        busy, done, div_check;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [37:0] ac;
        logic [35:0] mq;
        logic        dc;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    sm_muldiv uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .step_cnt(step_cnt), .mem_opnd(mem_opnd), .ac_in(ac_in), .mq_in(mq_in),
        .ac_out(ac_out), .mq_out(mq_out), .busy(busy), .done(done),
        .div_check(div_check)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    function automatic logic [37:0] mkac(input logic s, input logic [36:0] m);
        return {s, m};
    endfunction

    function automatic logic [35:0] mkmq(input logic s, input logic [34:0] m);
        return {s, m};
    endfunction

    // reference model written from the requirements
    task automatic model(input logic op, input logic [7:0] cnt, input logic [35:0] opnd,
                         input logic [37:0] ac, input logic [35:0] mq,
                         output logic [37:0] eac, output logic [35:0] emq,
                         output logic edc, output int lat);
        logic [36:0] a;
        logic [34:0] m, d;
        logic        s;
        a = ac[36:0]; m = mq[34:0]; d = opnd[34:0];
        eac = ac; emq = mq; edc = 1'b0; lat = 1;
        if (cnt != 0) begin
            if (!op) begin
                s = mq[35] ^ opnd[35];
                if (d == 0 || m == 0) begin
                    a = '0; m = '0;
                end else begin
                    for (int i = 0; i < cnt; i++) begin
                        if (m[0]) a = a + {2'b00, d};
                        m = {a[0], m[34:1]};
                        a = {1'b0, a[36:1]};
                    end
                    lat = cnt + 1;
                end
                eac = {s, a}; emq = {s, m};
            end else if (a >= {2'b00, d}) begin
                edc = 1'b1;
            end else begin
                for (int i = 0; i < cnt; i++) begin
                    a = {a[35:0], m[34]};
                    m = {m[33:0], 1'b0};
                    if (a >= {2'b00, d}) begin
                        a = a - {2'b00, d};
                        m[0] = 1'b1;
                    end
                end
                lat = cnt + 1;
                eac = {ac[37], a}; emq = {ac[37] ^ opnd[35], m};
            end
        end
    endtask

    // driver: pushes the expected item, drives the start, checks handshake timing
    task automatic run_op(input logic op, input logic [7:0] cnt, input logic [35:0] opnd,
                          input logic [37:0] ac, input logic [35:0] mq,
                          input string tag, input bit intrude);
        exp_t e;
        int   lat, n;
        bit   busy_ok;
        model(op, cnt, opnd, ac, mq, e.ac, e.mq, e.dc, lat);
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        start = 1'b1; op_sel = op; step_cnt = cnt;
        mem_opnd = opnd; ac_in = ac; mq_in = mq;
        @(negedge clk);
        start = 1'b0;
        n = 1; busy_ok = 1'b1;
        while (!done && n < 400) begin
            if (!busy) busy_ok = 1'b0;
            if (intrude && n == 2) begin
                start = 1'b1; op_sel = ~op; step_cnt = 8'd0;
                mem_opnd = ~opnd; ac_in = ~ac; mq_in = ~mq;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        check(n == lat, tag, "R8 latency", 64'(n), 64'(lat));
        check(busy_ok, tag, "R8 busy held until done", 64'(busy_ok), 64'd1);
        @(negedge clk);
        check(!done && !busy, tag, "R8 done single pulse", {62'd0, done, busy}, 64'd0);
    endtask

    // monitor: pops and compares on each done
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R9 unexpected done: actual=1 expected=0");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(ac_out == e.ac, e.tag, "accumulator", 64'(ac_out), 64'(e.ac));
                check(mq_out == e.mq, e.tag, "mq", 64'(mq_out), 64'(e.mq));
                check(div_check == e.dc, e.tag, "div_check", 64'(div_check), 64'(e.dc));
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R8 watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ac_out == '0 && mq_out == '0, "R8", "reset registers",
              64'(ac_out) | 64'(mq_out), 64'd0);
        check(!busy && !done && !div_check, "R8", "reset flags",
              {61'd0, busy, done, div_check}, 64'd0);

        // R1: zero count, both operations
        run_op(1'b0, 8'd0, mkmq(1, 35'h5), mkac(1, 37'h12345), mkmq(0, 35'h777), "R1 mul", 0);
        run_op(1'b1, 8'd0, mkmq(0, 35'h10), mkac(0, 37'h1000), mkmq(1, 35'h3), "R1 div", 0);

        // R2/R4: full multiply, all sign combinations
        run_op(1'b0, 8'd35, mkmq(0, 35'd11), mkac(0, 37'd0), mkmq(0, 35'd13), "R2 R4 ++", 0);
        run_op(1'b0, 8'd35, mkmq(0, 35'h7_FFFF_FFFF), mkac(1, 37'd0), mkmq(1, 35'h4_0000_0001), "R2 R4 -+", 0);
        run_op(1'b0, 8'd35, mkmq(1, 35'h1_2345_6789), mkac(0, 37'h1_2345), mkmq(0, 35'h0_ABCD_EF01), "R2 R4 +- accum", 0);
        run_op(1'b0, 8'd35, mkmq(1, 35'h7_FFFF_FFFF), mkac(1, 37'h1F_0000_0000), mkmq(1, 35'h7_FFFF_FFFF), "R2 R4 --", 0);
        run_op(1'b0, 8'd3, mkmq(0, 35'h55), mkac(0, 37'h3), mkmq(0, 35'h5), "R2 partial", 0);

        // R3: zero factor
        run_op(1'b0, 8'd35, mkmq(0, 35'd0), mkac(1, 37'h99), mkmq(1, 35'h5), "R3 opnd zero", 0);
        run_op(1'b0, 8'd20, mkmq(1, 35'h123), mkac(0, 37'h42), mkmq(0, 35'd0), "R3 mq zero", 0);

        // R10: long multiply
        run_op(1'b0, 8'd255, mkmq(0, 35'h6_1234_5678), mkac(0, 37'h0_0000_0001), mkmq(1, 35'h3_FFFF_0001), "R10 mul 255", 0);

        // R6/R7: divide, signs
        run_op(1'b1, 8'd35, mkmq(0, 35'd7), mkac(0, 37'd0), mkmq(0, 35'd100), "R6 div ++", 0);
        run_op(1'b1, 8'd35, mkmq(0, 35'd7), mkac(1, 37'd0), mkmq(0, 35'd100), "R7 div -+", 0);
        run_op(1'b1, 8'd35, mkmq(1, 35'd7), mkac(1, 37'd0), mkmq(1, 35'd100), "R7 div --", 0);
        run_op(1'b1, 8'd35, mkmq(1, 35'd10), mkac(0, 37'd3), mkmq(0, 35'h1234), "R6 R7 div high part", 0);

        // R5: refusal
        run_op(1'b1, 8'd35, mkmq(0, 35'd10), mkac(1, 37'd10), mkmq(0, 35'h55), "R5 equal", 0);
        run_op(1'b1, 8'd35, mkmq(0, 35'h7_FFFF_FFFF), mkac(0, 37'h10_0000_0000), mkmq(1, 35'h1), "R5 Q bit", 0);
        run_op(1'b1, 8'd35, mkmq(0, 35'd10), mkac(0, 37'd9), mkmq(0, 35'h7_0000_0000), "R5 just below", 0);

        // R10: long divide
        run_op(1'b1, 8'd200, mkmq(0, 35'h5_5555_5555), mkac(1, 37'h1_2345_6789), mkmq(0, 35'h2_0000_0003), "R10 div 200", 0);

        // R9: start during run ignored
        run_op(1'b0, 8'd10, mkmq(0, 35'h3F), mkac(0, 37'h1), mkmq(1, 35'h2AB), "R9 mul intrude", 1);
        run_op(1'b1, 8'd12, mkmq(1, 35'h100), mkac(0, 37'h20), mkmq(0, 35'hFFF), "R9 div intrude", 1);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R9", "scoreboard drained", 64'(exp_q.size()), 64'd0);

        finish_run();
    end
endmodule